// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the clocked front end of a flow-through synchronous SRAM model. The word is 32 bits wide and is split into four 8-bit byte lanes. On every rising clock edge the block samples the address, three chip selects, two address strobes, a burst-advance input and the write controls. From these it decides whether the cycle deselects the device, starts a burst at the external address, steps the burst to its next address, or holds the burst at its current address. It then writes the behavioural array lane by lane, or presents read data.

Read data is flow-through. The word at the address registered on an edge appears on `rdata_o` during the cycle that follows that edge. No further output register is added. The drive-enable output `drive_o` stands in for a tri-state pad. It follows the output-enable input without waiting for a clock. Burst offsets come from a separate generator, which has a load/advance interface and supports two orderings: a counting order and an exclusive-or order. A parent design uses the block as a cycle-accurate memory behind a pipelined bus master.

Top module: `sburst_sram_ctrl`

## Requirements
- R1: A synchronous reset clears the selection state. After reset, `drive_o` is 0 and `rdata_o` is 0. A following cycle with both strobes high drives nothing.
- R2: Suppose `proc_strb_n_i`=0 and `sel_n_i`=0, and the secondary selects enable the device (`sel_hi_i`=1, `sel_lo_n_i`=0). Then the cycle loads `addr_i` and starts a read, even when the write controls request a write.
- R3: With `sel_n_i`=1 the processor strobe has no effect. If `ctrl_strb_n_i` is also high, the cycle behaves as one with both strobes high. With `sel_n_i`=1 and `ctrl_strb_n_i`=0 the device deselects and stops driving.
- R4: A strobe cycle where `sel_hi_i`=0 or `sel_lo_n_i`=1 deselects the device, with no drive in the next cycle.
- R5: Suppose `proc_strb_n_i`=1, `ctrl_strb_n_i`=0 and all selects are active. Then the cycle loads `addr_i` and starts a write if a write is requested, otherwise a read.
- R6: The secondary selects are sampled only on strobe cycles. With both strobes high, their values do not change the selection.
- R7: With both strobes high and the device selected, `burst_adv_n_i`=0 steps to the next address in the burst. The two low address bits are the offset, and the upper bits are kept. With `interleave_i`=0 the offset is (start+k) mod 4. With `interleave_i`=1 it is start XOR k.
- R8: With both strobes high and `burst_adv_n_i`=1, the burst holds its current address. The cycle is a read or a write according to the write controls.
- R9: `all_wr_n_i`=0 writes all four lanes. Otherwise, `lane_wr_en_n_i`=0 writes each lane i whose `lane_sel_n_i[i]`=0. Lane i covers data bits 8i+7..8i. When both `all_wr_n_i` and `lane_wr_en_n_i` are 1, the cycle is a read.
- R10: A write placed in the cycle after a processor-strobe start (both strobes high, advance high) stores to that start address.
- R11: A read's word appears in the cycle right after the edge that registered its address.
- R12: `drive_o`=1 only after a read cycle and while `out_en_n_i`=0. It reacts to `out_en_n_i` without a clock. It is 0 during deselect and after write cycles. `rdata_o` is 0 whenever `drive_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| interleave_i | input | 1 | Burst order: 0 counting, 1 exclusive-or; static outside reset |
| addr_i | input | ADDR_W | External word address |
| sel_n_i | input | 1 | Primary select, active low; gates the processor strobe |
| sel_hi_i | input | 1 | Secondary select, active high |
| sel_lo_n_i | input | 1 | Secondary select, active low |
| proc_strb_n_i | input | 1 | Processor address strobe, active low, read start only |
| ctrl_strb_n_i | input | 1 | Controller address strobe, active low |
| burst_adv_n_i | input | 1 | Burst advance, active low |
| all_wr_n_i | input | 1 | Global write, active low |
| lane_wr_en_n_i | input | 1 | Qualifier for per-lane writes, active low |
| lane_sel_n_i | input | LANES | Per-lane write selects, active low |
| out_en_n_i | input | 1 | Output enable, active low, asynchronous |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driving |
| drive_o | output | 1 | Output drive enable |

## Verification
The bench uses the default parameters: 64 words, four 8-bit lanes and a 2-bit burst offset. The small array can be filled completely by sixteen directed four-beat write bursts. After that fill, random addresses collide often, so read-after-write and partial lane writes are checked against known contents. The 2-bit offset lets both burst orders wrap within a few cycles, so every start offset and both wrap points come up repeatedly in each random phase. One random phase runs in each order.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    SBS_IDLE,
    SBS_DESEL,
    SBS_LOAD,
    SBS_NEXT,
    SBS_HOLD
  } sbs_op_e;
endpackage

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen #(
  parameter int ADDR_W = 6,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              interleave_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  localparam int BASE_W = ADDR_W - OFS_W;

  logic [BASE_W-1:0] base_q;
  logic [OFS_W-1:0]  start_q;
  logic [OFS_W-1:0]  cnt_q;
  logic [OFS_W-1:0]  cnt_nxt;

  function automatic logic [OFS_W-1:0] ofs_of(input logic il,
                                               input logic [OFS_W-1:0] s,
                                               input logic [OFS_W-1:0] k);
    return il ? (s ^ k) : OFS_W'(s + k);
  endfunction

  assign cnt_nxt    = OFS_W'(cnt_q + 1'b1);
  assign cur_addr_o = {base_q, ofs_of(interleave_i, start_q, cnt_q)};
  assign nxt_addr_o = {base_q, ofs_of(interleave_i, start_q, cnt_nxt)};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      base_q  <= load_addr_i[ADDR_W-1:OFS_W];
      start_q <= load_addr_i[OFS_W-1:0];
      cnt_q   <= '0;
    end else if (adv_i) begin
      cnt_q   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode #(
  parameter int LANES = 4
) (
  input  logic             proc_strb_n_i,
  input  logic             ctrl_strb_n_i,
  input  logic             sel_n_i,
  input  logic             sel_hi_i,
  input  logic             sel_lo_n_i,
  input  logic             burst_adv_n_i,
  input  logic             all_wr_n_i,
  input  logic             lane_wr_en_n_i,
  input  logic [LANES-1:0] lane_sel_n_i,
  input  logic             selected_i,
  output sbs_pkg::sbs_op_e op_o,
  output logic             wr_o,
  output logic [LANES-1:0] lane_we_o
);
  import sbs_pkg::*;

  logic             second_ok;
  logic [LANES-1:0] mask;

  always_comb begin
    second_ok = sel_hi_i & ~sel_lo_n_i;
    if (!all_wr_n_i)          mask = '1;
    else if (!lane_wr_en_n_i) mask = ~lane_sel_n_i;
    else                      mask = '0;

    op_o = SBS_IDLE;
    wr_o = 1'b0;
    if (!proc_strb_n_i && !sel_n_i) begin
      // processor strobe: read start, write controls ignored
      op_o = second_ok ? SBS_LOAD : SBS_DESEL;
    end else if (!ctrl_strb_n_i) begin
      if (!sel_n_i && second_ok) begin
        op_o = SBS_LOAD;
        wr_o = |mask;
      end else begin
        op_o = SBS_DESEL;
      end
    end else if (selected_i) begin
      op_o = burst_adv_n_i ? SBS_HOLD : SBS_NEXT;
      wr_o = |mask;
    end
    lane_we_o = wr_o ? mask : '0;
  end
endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sburst_sram_ctrl.sv
module sburst_sram_ctrl #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int OFS_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    interleave_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    sel_n_i,
  input  logic                    sel_hi_i,
  input  logic                    sel_lo_n_i,
  input  logic                    proc_strb_n_i,
  input  logic                    ctrl_strb_n_i,
  input  logic                    burst_adv_n_i,
  input  logic                    all_wr_n_i,
  input  logic                    lane_wr_en_n_i,
  input  logic [LANES-1:0]        lane_sel_n_i,
  input  logic                    out_en_n_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);
  import sbs_pkg::*;

  localparam int DATA_W = LANES * LANE_W;

  sbs_op_e           op;
  logic              wr;
  logic [LANES-1:0]  lane_we;
  logic              sel_q;
  logic              rd_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] rd_word;

  sbs_cycle_decode #(.LANES(LANES)) dec_i (
    .proc_strb_n_i (proc_strb_n_i),
    .ctrl_strb_n_i (ctrl_strb_n_i),
    .sel_n_i       (sel_n_i),
    .sel_hi_i      (sel_hi_i),
    .sel_lo_n_i    (sel_lo_n_i),
    .burst_adv_n_i (burst_adv_n_i),
    .all_wr_n_i    (all_wr_n_i),
    .lane_wr_en_n_i(lane_wr_en_n_i),
    .lane_sel_n_i  (lane_sel_n_i),
    .selected_i    (sel_q),
    .op_o          (op),
    .wr_o          (wr),
    .lane_we_o     (lane_we)
  );

  sbs_burst_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) bgen_i (
    .clk         (clk),
    .rst         (rst),
    .load_i      (op == SBS_LOAD),
    .adv_i       (op == SBS_NEXT),
    .interleave_i(interleave_i),
    .load_addr_i (addr_i),
    .cur_addr_o  (cur_addr),
    .nxt_addr_o  (nxt_addr)
  );

  always_comb begin
    case (op)
      SBS_LOAD: eff_addr = addr_i;
      SBS_NEXT: eff_addr = nxt_addr;
      default:  eff_addr = cur_addr;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sbs_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) mem_i (
      .clk    (clk),
      .we_i   (lane_we[l]),
      .waddr_i(eff_addr),
      .wdata_i(wdata_i[l*LANE_W +: LANE_W]),
      .raddr_i(cur_addr),
      .rdata_o(rd_word[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      case (op)
        SBS_DESEL: sel_q <= 1'b0;
        SBS_LOAD:  sel_q <= 1'b1;
        default:   sel_q <= sel_q;
      endcase
      rd_q <= (op == SBS_LOAD || op == SBS_NEXT || op == SBS_HOLD) && !wr;
    end
  end

  assign drive_o = rd_q & ~out_en_n_i;
  assign rdata_o = drive_o ? rd_word : '0;
endmodule

// File: rtl/sbs_sram_chk.sv
module sbs_sram_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n_i,
  input logic              sel_hi_i,
  input logic              sel_lo_n_i,
  input logic              proc_strb_n_i,
  input logic              ctrl_strb_n_i,
  input logic              burst_adv_n_i,
  input logic              all_wr_n_i,
  input logic              lane_wr_en_n_i,
  input logic              out_en_n_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              drive_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !drive_o);

  // R2
  proc_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!proc_strb_n_i && !sel_n_i && sel_hi_i && !sel_lo_n_i) |=> (drive_o || out_en_n_i));

  // R3
  ctrl_desel_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_n_i && !ctrl_strb_n_i) |=> !drive_o);

  // R4
  second_desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_n_i && !(sel_hi_i && !sel_lo_n_i) && (!proc_strb_n_i || !ctrl_strb_n_i)) |=> !drive_o);

  // R12
  write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (proc_strb_n_i && !all_wr_n_i) |=> !drive_o);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_o && proc_strb_n_i && ctrl_strb_n_i && burst_adv_n_i && all_wr_n_i && lane_wr_en_n_i)
    |=> (!drive_o || $stable(rdata_o)));
endmodule

bind sburst_sram_ctrl sbs_sram_chk #(.DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .sel_n_i       (sel_n_i),
  .sel_hi_i      (sel_hi_i),
  .sel_lo_n_i    (sel_lo_n_i),
  .proc_strb_n_i (proc_strb_n_i),
  .ctrl_strb_n_i (ctrl_strb_n_i),
  .burst_adv_n_i (burst_adv_n_i),
  .all_wr_n_i    (all_wr_n_i),
  .lane_wr_en_n_i(lane_wr_en_n_i),
  .out_en_n_i    (out_en_n_i),
  .rdata_o       (rdata_o),
  .drive_o       (drive_o)
);

// File: tb/sburst_sram_ctrl_tb_top.sv
module sburst_sram_ctrl_tb_top;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int OFS_W  = 2;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, interleave, sel_n, sel_hi, sel_lo_n, proc_n, ctrl_n, adv_n, gw_n, lwe_n, oe_n;
  logic [ADDR_W-1:0] addr;
  logic [LANES-1:0]  lsel_n;
  logic [DATA_W-1:0] wdata, rdata;
  logic              drive;

  sburst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .OFS_W(OFS_W)) dut_i (
    .clk(clk), .rst(rst), .interleave_i(interleave), .addr_i(addr),
    .sel_n_i(sel_n), .sel_hi_i(sel_hi), .sel_lo_n_i(sel_lo_n),
    .proc_strb_n_i(proc_n), .ctrl_strb_n_i(ctrl_n), .burst_adv_n_i(adv_n),
    .all_wr_n_i(gw_n), .lane_wr_en_n_i(lwe_n), .lane_sel_n_i(lsel_n),
    .out_en_n_i(oe_n), .wdata_i(wdata), .rdata_o(rdata), .drive_o(drive)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [DATA_W-1:0]        m_mem [DEPTH];
  bit                       m_sel, m_rd;
  logic [ADDR_W-OFS_W-1:0]  m_base;
  logic [OFS_W-1:0]         m_start, m_cnt;

  function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
    logic [7:0] b = 8'(a);
    return {b, b ^ 8'h5A, ~b, 8'(b + 8'h33)};
  endfunction

  function automatic logic [ADDR_W-1:0] m_addr();
    logic [OFS_W-1:0] o = interleave ? (m_start ^ m_cnt) : OFS_W'(m_start + m_cnt);
    return {m_base, o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [LANES-1:0]  mask;
    logic [ADDR_W-1:0] a;
    bit sec = sel_hi && !sel_lo_n;
    bit wr, act;
    if (!gw_n)       mask = '1;
    else if (!lwe_n) mask = ~lsel_n;
    else             mask = '0;
    act = 0; wr = 0;
    if (rst) begin
      m_sel = 0; m_rd = 0; m_base = '0; m_start = '0; m_cnt = '0;
      return;
    end
    if (!proc_n && !sel_n) begin
      if (sec) begin
        m_base = addr[ADDR_W-1:OFS_W]; m_start = addr[OFS_W-1:0]; m_cnt = '0;
        m_sel = 1; act = 1;
      end else m_sel = 0;
    end else if (!ctrl_n) begin
      if (!sel_n && sec) begin
        m_base = addr[ADDR_W-1:OFS_W]; m_start = addr[OFS_W-1:0]; m_cnt = '0;
        m_sel = 1; act = 1; wr = |mask;
      end else m_sel = 0;
    end else if (m_sel) begin
      if (!adv_n) m_cnt = OFS_W'(m_cnt + 1'b1);
      act = 1; wr = |mask;
    end
    if (act && wr) begin
      a = m_addr();
      for (int l = 0; l < LANES; l++)
        if (mask[l]) m_mem[a][l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
    end
    m_rd = act && !wr;
  endtask

  // one clock: model follows the edge, outputs compared half a cycle later
  task automatic tick(input string tag);
    logic [DATA_W-1:0] ed;
    bit edv;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    edv = m_rd && !oe_n;
    ed  = edv ? m_mem[m_addr()] : '0;
    chk(drive === edv, {tag, " drive"}, DATA_W'(drive), DATA_W'(edv));
    chk(rdata === ed, {tag, " data"}, rdata, ed);
  endtask

  task automatic quiet();
    sel_n = 0; sel_hi = 1; sel_lo_n = 0; proc_n = 1; ctrl_n = 1; adv_n = 1;
    gw_n = 1; lwe_n = 1; lsel_n = '1; oe_n = 0; addr = '0; wdata = '0;
  endtask

  task automatic do_reset(input bit il);
    quiet(); rst = 1; interleave = il;
    tick("R1 reset"); tick("R1 reset");
    rst = 0;
  endtask

  task automatic proc_read(input logic [ADDR_W-1:0] a, input string tag);
    quiet(); proc_n = 0; addr = a; tick(tag);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] p;
    void'($urandom(32'd2718));
    rst = 1; interleave = 0; quiet();
    @(negedge clk);
    do_reset(0);
    // R1: a both-strobes-high cycle after reset drives nothing
    quiet(); tick("R1 idle");
    chk(drive === 1'b0 && rdata === '0, "R1 no drive", rdata, '0);

    // fill with four-beat write bursts (R5 start, R7 continue)
    for (int b = 0; b < DEPTH / 4; b++) begin
      quiet(); ctrl_n = 0; gw_n = 0; addr = ADDR_W'(b * 4); wdata = pat(addr);
      tick("R5 write start");
      for (int k = 1; k < 4; k++) begin
        quiet(); adv_n = 0; gw_n = 0; wdata = pat(ADDR_W'(b * 4 + k));
        tick("R7 write next");
      end
    end

    // R2: processor strobe reads even with global write low; R11 same-cycle data
    quiet(); proc_n = 0; gw_n = 0; addr = 6'd9; tick("R2 start");
    chk(rdata === pat(6'd9), "R2 R11 first word", rdata, pat(6'd9));
    // R7 counting order from offset 1: 10, 11, 8
    quiet(); adv_n = 0; tick("R7 lin");
    chk(rdata === pat(6'd10), "R7 lin k1", rdata, pat(6'd10));
    quiet(); adv_n = 0; tick("R7 lin");
    quiet(); adv_n = 0; tick("R7 lin");
    chk(rdata === pat(6'd8), "R7 lin wrap", rdata, pat(6'd8));
    // R8 hold
    quiet(); tick("R8 hold");
    chk(rdata === pat(6'd8), "R8 hold read", rdata, pat(6'd8));

    // R10 + R9: write lanes 0 and 2 in the cycle after a processor start
    proc_read(6'd20, "R10 start");
    quiet(); lwe_n = 0; lsel_n = 4'b1010; wdata = 32'hDEADBEEF; tick("R10 write");
    chk(drive === 1'b0, "R12 write no drive", DATA_W'(drive), 0);
    proc_read(6'd20, "R10 readback");
    p = pat(6'd20);
    p = {p[31:24], 8'hAD, p[15:8], 8'hEF};
    chk(rdata === p, "R9 R10 lane write", rdata, p);

    // R9 / R5: lane enables without qualifier make a read
    quiet(); ctrl_n = 0; lsel_n = '0; addr = 6'd21; wdata = '1; tick("R5 read start");
    chk(rdata === pat(6'd21), "R9 no qualifier read", rdata, pat(6'd21));
    // R9: global write overrides lane controls
    quiet(); ctrl_n = 0; gw_n = 0; addr = 6'd22; wdata = 32'h01234567; tick("R9 global");
    proc_read(6'd22, "R9 readback");
    chk(rdata === 32'h01234567, "R9 global all lanes", rdata, 32'h01234567);

    // R3: primary select high masks processor strobe -> hold at 22
    quiet(); sel_n = 1; proc_n = 0; addr = 6'd40; tick("R3 masked");
    chk(rdata === 32'h01234567, "R3 strobe ignored", rdata, 32'h01234567);
    quiet(); sel_n = 1; ctrl_n = 0; tick("R3 desel");
    chk(drive === 1'b0, "R3 deselect", DATA_W'(drive), 0);

    // R4: secondary selects deselect
    proc_read(6'd3, "R4 pre");
    quiet(); proc_n = 0; sel_hi = 0; addr = 6'd3; tick("R4 hi");
    chk(drive === 1'b0, "R4 sel_hi low", DATA_W'(drive), 0);
    proc_read(6'd3, "R4 pre");
    quiet(); ctrl_n = 0; sel_lo_n = 1; addr = 6'd3; tick("R4 lo");
    chk(drive === 1'b0, "R4 sel_lo_n high", DATA_W'(drive), 0);

    // R6: secondary selects ignored without a strobe
    proc_read(6'd4, "R6 start");
    quiet(); adv_n = 0; sel_hi = 0; sel_lo_n = 1; tick("R6 next");
    chk(rdata === pat(6'd5), "R6 carry selection", rdata, pat(6'd5));

    // R12: asynchronous output enable
    #1 oe_n = 1; #1;
    chk(drive === 1'b0 && rdata === '0, "R12 oe off", rdata, '0);
    oe_n = 0; #1;
    chk(drive === 1'b1 && rdata === pat(6'd5), "R12 oe on", rdata, pat(6'd5));
    @(negedge clk);

    // R7 exclusive-or order from offset 2: 6, 7, 4, 5
    do_reset(1);
    proc_read(6'd6, "R7 il start");
    quiet(); adv_n = 0; tick("R7 il");
    chk(rdata === pat(6'd7), "R7 il k1", rdata, pat(6'd7));
    quiet(); adv_n = 0; tick("R7 il");
    chk(rdata === pat(6'd4), "R7 il k2", rdata, pat(6'd4));
    quiet(); adv_n = 0; tick("R7 il");
    chk(rdata === pat(6'd5), "R7 il k3", rdata, pat(6'd5));

    // random phases, one per burst order
    for (int md = 0; md < 2; md++) begin
      do_reset(md[0]);
      for (int n = 0; n < 3000; n++) begin
        proc_n   = ($urandom % 4) != 0;
        ctrl_n   = ($urandom % 3) != 0;
        sel_n    = ($urandom % 6) == 0;
        sel_hi   = ($urandom % 8) != 0;
        sel_lo_n = ($urandom % 8) == 0;
        adv_n    = 1'($urandom % 2);
        gw_n     = ($urandom % 4) != 0;
        lwe_n    = 1'($urandom % 2);
        lsel_n   = LANES'($urandom);
        oe_n     = ($urandom % 5) == 0;
        addr     = ADDR_W'($urandom);
        wdata    = $urandom;
        tick("R11 R12 random");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule